// File: doc/BRIEF.md
# SPI Opcode Command Decoder

This block is the serial command front end of a receiver device. An external SPI master (mode 0: SCK idles low, data changes on falling edges and is sampled on rising edges) lowers chip select, shifts in an 8-bit opcode most significant bit first, and then either shifts in a data field or shifts out a data field. The length of that field depends on the opcode. The block samples the serial pins with the system clock, decodes each opcode, and drives single-cycle strobes plus data buses toward the control register, the clock-divider register, the label table and the receive FIFO. All of that storage sits outside this block.

Some opcodes act as soon as the eighth opcode bit has been captured, while chip select is still low: master reset, clear all labels and set all labels. Opcodes with no function are decoded and then ignored. Raising chip select at any moment ends the transfer and returns the decoder to the opcode phase, and a partly shifted write is dropped.

Top module: `spi_cmd_decoder`

## Requirements
- R1: While `cs_n` is high, `so` is 0. After reset, no strobe is active.
- R2: Opcode 0x01 pulses `mr_pulse` exactly once, right after the eighth opcode bit is captured and before `cs_n` rises.
- R3: Opcode 0x02 pulses `lbl_all_clr` and opcode 0x03 pulses `lbl_all_set`. Each pulses once, after the eighth opcode bit, with `cs_n` still low.
- R4: Opcode 0x10 followed by 16 data bits, MSB first, gives one `ctrl_we` pulse. During that pulse `ctrl_wdata` holds the 16 bits.
- R5: Opcode 0x07 followed by 8 data bits gives one `div_we` pulse. During that pulse `div_wdata` holds the 8 bits.
- R6: Opcode 0x04 (clear) or 0x05 (set) followed by an 8-bit address gives one `lbl_we` pulse. During that pulse `lbl_addr` holds the address and `lbl_wbit` is 0 for 0x04 and 1 for 0x05.
- R7: Opcode 0x06 followed by 256 data bits gives 256 `lbl_we` pulses. The addresses run from 0xFF down to 0x00, and each pulse carries its data bit on `lbl_wbit`.
- R8: Opcodes 0x0A, 0x0B and 0x0C shift out the status byte, the control word and the divider byte, MSB first. The MSB appears on `so` at the first falling SCK edge after the last opcode bit. Bits past the end of the register read as 0.
- R9: Opcode 0x08 shifts out the head FIFO word (32 bits, MSB first) and pops it with one `fifo_pop` pulse. When the FIFO is empty it shifts out zeros and does not pop.
- R10: Opcode 0x09 shifts out stored FIFO words back to back with no gap, popping each one. Once the FIFO is empty it shifts out zeros.
- R11: Opcode 0x0D shifts out the label table one bit per SCK, starting at address 0xFF and going down.
- R12: Opcodes 0x00, 0x0E, 0x0F and 0x11 through 0xFF cause no strobe and leave `so` at 0, whatever data follows them.
- R13: If `cs_n` rises before a write field is complete, that write produces no strobe. The next transfer decodes a fresh opcode.
- R14: SCK bits sent after a write field is complete are ignored and cause no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | Serial data in from the master |
| so | output | 1 | Serial data out to the master, 0 while deselected |
| mr_pulse | output | 1 | Master reset strobe |
| ctrl_we | output | 1 | Control register write strobe |
| ctrl_wdata | output | 16 | Control register write data |
| ctrl_rdata | input | 16 | Current control register value |
| stat_rdata | input | 8 | Current status register value |
| fifo_pop | output | 1 | Receive FIFO pop strobe |
| fifo_empty | input | 1 | Receive FIFO empty flag |
| fifo_rdata | input | 32 | Receive FIFO head word |
| div_we | output | 1 | Clock-divider write strobe |
| div_wdata | output | 8 | Clock-divider write data |
| div_rdata | input | 8 | Current clock-divider value |
| lbl_all_clr | output | 1 | Clear-all-labels strobe |
| lbl_all_set | output | 1 | Set-all-labels strobe |
| lbl_we | output | 1 | Single label bit write strobe |
| lbl_addr | output | 8 | Label table address for writes and reads |
| lbl_wbit | output | 1 | Label bit value to write |
| lbl_rbit | input | 1 | Label table bit at `lbl_addr` |

## Verification
The assertions rely on three things about the inputs. SCK half periods last several system clocks. `cs_n` stays low for some clocks after the last SCK edge of a transfer. SCK is low whenever `cs_n` falls. Under those conditions strobes come out as isolated single pulses and never overlap one another. The bench keeps to these conditions: it drives SCK with a half period of eight clocks, holds chip select for ten clocks on each side of the SCK activity, and only changes `si` while SCK is low. It also models the FIFO and the label table as plain registers whose read data follows the block's pop strobe and address.

// File: rtl/spi_cmd_decoder.sv
`timescale 1ns/1ps
module spi_cmd_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        si,
  output logic        so,
  output logic        mr_pulse,
  output logic        ctrl_we,
  output logic [15:0] ctrl_wdata,
  input  logic [15:0] ctrl_rdata,
  input  logic [7:0]  stat_rdata,
  output logic        fifo_pop,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_rdata,
  output logic        div_we,
  output logic [7:0]  div_wdata,
  input  logic [7:0]  div_rdata,
  output logic        lbl_all_clr,
  output logic        lbl_all_set,
  output logic        lbl_we,
  output logic [7:0]  lbl_addr,
  output logic        lbl_wbit,
  input  logic        lbl_rbit
);
  typedef enum logic [1:0] {PH_OP, PH_WR, PH_RD, PH_DONE} phase_t;

  logic [2:0]  sck_s, cs_s, si_s;
  logic        sck_rise, sck_fall, sel, sdi;
  phase_t      ph;
  logic [7:0]  opc;
  logic [8:0]  bcnt, wr_len;
  logic [31:0] sh;
  logic        so_q;
  logic [7:0]  op_full;
  logic [31:0] sh_in, next_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      si_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s  <= {cs_s[1:0], cs_n};
      si_s  <= {si_s[1:0], si};
    end

  assign sck_rise  = sck_s[1] & ~sck_s[2];
  assign sck_fall  = ~sck_s[1] & sck_s[2];
  assign sel       = ~cs_s[1];
  assign sdi       = si_s[1];
  assign op_full   = {opc[6:0], sdi};
  assign sh_in     = {sh[30:0], sdi};
  assign next_word = fifo_empty ? 32'd0 : fifo_rdata;
  assign so        = so_q & ~cs_n;
  assign ctrl_wdata = sh[15:0];
  assign div_wdata  = sh[7:0];

  always_comb
    case (opc)
      8'h10:   wr_len = 9'd16;
      8'h06:   wr_len = 9'd256;
      default: wr_len = 9'd8;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= PH_OP;
      opc <= '0;
      bcnt <= '0;
      sh <= '0;
      so_q <= 1'b0;
      lbl_addr <= '0;
      lbl_wbit <= 1'b0;
      mr_pulse <= 1'b0;
      ctrl_we <= 1'b0;
      fifo_pop <= 1'b0;
      div_we <= 1'b0;
      lbl_all_clr <= 1'b0;
      lbl_all_set <= 1'b0;
      lbl_we <= 1'b0;
    end else begin
      mr_pulse <= 1'b0;
      ctrl_we <= 1'b0;
      fifo_pop <= 1'b0;
      div_we <= 1'b0;
      lbl_all_clr <= 1'b0;
      lbl_all_set <= 1'b0;
      lbl_we <= 1'b0;
      if (!sel) begin
        ph <= PH_OP;
        bcnt <= '0;
        so_q <= 1'b0;
      end else if (sck_rise) begin
        case (ph)
          PH_OP: begin
            opc <= op_full;
            bcnt <= bcnt + 9'd1;
            if (bcnt == 9'd7) begin
              bcnt <= '0;
              ph <= PH_DONE;
              case (op_full)
                8'h01: mr_pulse <= 1'b1;
                8'h02: lbl_all_clr <= 1'b1;
                8'h03: lbl_all_set <= 1'b1;
                8'h04, 8'h05, 8'h07, 8'h10: ph <= PH_WR;
                8'h06: begin ph <= PH_WR; lbl_addr <= 8'h00; end
                8'h08, 8'h09: begin
                  ph <= PH_RD;
                  sh <= next_word;
                  fifo_pop <= ~fifo_empty;
                end
                8'h0A: begin ph <= PH_RD; sh <= {stat_rdata, 24'd0}; end
                8'h0B: begin ph <= PH_RD; sh <= {ctrl_rdata, 16'd0}; end
                8'h0C: begin ph <= PH_RD; sh <= {div_rdata, 24'd0}; end
                8'h0D: begin ph <= PH_RD; lbl_addr <= 8'hFF; end
                default: ;
              endcase
            end
          end
          PH_WR: begin
            sh <= sh_in;
            bcnt <= bcnt + 9'd1;
            if (opc == 8'h06) begin
              lbl_we <= 1'b1;
              lbl_wbit <= sdi;
              lbl_addr <= lbl_addr - 8'd1;
            end
            if (bcnt == wr_len - 9'd1) begin
              ph <= PH_DONE;
              case (opc)
                8'h10: ctrl_we <= 1'b1;
                8'h07: div_we <= 1'b1;
                8'h04, 8'h05: begin
                  lbl_we <= 1'b1;
                  lbl_addr <= sh_in[7:0];
                  lbl_wbit <= opc[0];
                end
                default: ;
              endcase
            end
          end
          default: ;
        endcase
      end else if (sck_fall && ph == PH_RD) begin
        if (opc == 8'h0D) begin
          so_q <= lbl_rbit;
          lbl_addr <= lbl_addr - 8'd1;
        end else begin
          so_q <= sh[31];
          bcnt <= bcnt + 9'd1;
          if (opc == 8'h09 && bcnt[4:0] == 5'd31) begin
            sh <= next_word;
            fifo_pop <= ~fifo_empty;
          end else begin
            sh <= {sh[30:0], 1'b0};
          end
        end
      end
    end
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
`timescale 1ns/1ps
module spi_cmd_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so,
  input logic mr_pulse,
  input logic ctrl_we,
  input logic fifo_pop,
  input logic fifo_empty,
  input logic div_we,
  input logic lbl_all_clr,
  input logic lbl_all_set,
  input logic lbl_we
);
  p_so_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so);

  p_mr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mr_pulse |=> !mr_pulse);

  p_all_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lbl_all_clr || lbl_all_set) |-> !cs_n);

  p_lbl_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_we |=> !lbl_we);

  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  p_strobe_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mr_pulse, ctrl_we, fifo_pop, div_we, lbl_all_clr, lbl_all_set, lbl_we}));

  p_ctrl_in_select_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || div_we) |-> !cs_n);
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so),
  .mr_pulse(mr_pulse), .ctrl_we(ctrl_we), .fifo_pop(fifo_pop),
  .fifo_empty(fifo_empty), .div_we(div_we), .lbl_all_clr(lbl_all_clr),
  .lbl_all_set(lbl_all_set), .lbl_we(lbl_we)
);

// File: tb/spi_cmd_decoder_test.sv
`timescale 1ns/1ps
module spi_cmd_decoder_test;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic so, mr_pulse, ctrl_we, fifo_pop, div_we, lbl_all_clr, lbl_all_set, lbl_we, lbl_wbit;
  logic [15:0] ctrl_wdata, ctrl_reg = 16'h0000;
  logic [7:0]  div_wdata, div_reg = 8'h00, lbl_addr;
  logic [7:0]  stat_reg = 8'h5A;
  logic [255:0] tbl = '0;
  logic [31:0] fq [0:7];
  logic [2:0]  hd = 0, tl = 0;
  logic        fifo_empty;
  logic [31:0] fifo_rdata;
  int n_mr = 0, n_clr = 0, n_set = 0, n_ctrl = 0, n_div = 0, n_lbl = 0, n_pop = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  assign fifo_empty = (hd == tl);
  assign fifo_rdata = fq[hd];

  spi_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .mr_pulse(mr_pulse), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_reg), .stat_rdata(stat_reg), .fifo_pop(fifo_pop),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .div_we(div_we),
    .div_wdata(div_wdata), .div_rdata(div_reg), .lbl_all_clr(lbl_all_clr),
    .lbl_all_set(lbl_all_set), .lbl_we(lbl_we), .lbl_addr(lbl_addr),
    .lbl_wbit(lbl_wbit), .lbl_rbit(tbl[lbl_addr])
  );

  always @(posedge clk) begin
    if (mr_pulse) n_mr++;
    if (lbl_all_clr) begin n_clr++; tbl <= '0; end
    if (lbl_all_set) begin n_set++; tbl <= '1; end
    if (ctrl_we) begin n_ctrl++; ctrl_reg <= ctrl_wdata; end
    if (div_we) begin n_div++; div_reg <= div_wdata; end
    if (lbl_we) begin n_lbl++; tbl[lbl_addr] <= lbl_wbit; end
    if (fifo_pop) begin n_pop++; hd <= hd + 3'd1; end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    si = b; #80; r = so; sck = 1; #80; sck = 0;
  endtask

  task automatic xfer(input logic [7:0] op, input int nw, input logic [255:0] wd,
                      input int nr, output logic [255:0] rd);
    logic r;
    rd = '0;
    cs_n = 0; #100;
    for (int i = 7; i >= 0; i--) sbit(op[i], r);
    for (int i = nw - 1; i >= 0; i--) sbit(wd[i], r);
    for (int i = nr - 1; i >= 0; i--) begin sbit(1'b0, r); rd[i] = r; end
    #100; cs_n = 1; #200;
  endtask

  task automatic push(input logic [31:0] w);
    fq[tl] = w; tl = tl + 3'd1;
  endtask

  task automatic t_reset;
    chk("R1 so idle after reset", so, 0);
    chk("R1 no strobes after reset", n_mr + n_ctrl + n_div + n_lbl + n_pop + n_clr + n_set, 0);
  endtask

  task automatic t_mreset;
    logic r;
    cs_n = 0; #100;
    for (int i = 7; i >= 0; i--) sbit(i == 0, r);
    #100;
    chk("R2 master reset before cs rise", n_mr, 1);
    cs_n = 1; #200;
    chk("R2 master reset single pulse", n_mr, 1);
  endtask

  task automatic t_all;
    logic [255:0] rd;
    logic r;
    cs_n = 0; #100;
    for (int i = 7; i >= 0; i--) sbit(i < 2, r);
    #100;
    chk("R3 set all while selected", n_set, 1);
    cs_n = 1; #200;
    chk("R3 table all ones", tbl, {256{1'b1}});
    xfer(8'h02, 0, 0, 0, rd);
    chk("R3 clear all count", n_clr, 1);
    chk("R3 table all zeros", tbl, 0);
  endtask

  task automatic t_ctrl;
    logic [255:0] rd;
    xfer(8'h10, 16, 256'hA5C3, 0, rd);
    chk("R4 control write value", ctrl_reg, 16'hA5C3);
    chk("R4 control write count", n_ctrl, 1);
    xfer(8'h10, 20, 256'h3C96F, 0, rd);
    chk("R14 extra bits ignored value", ctrl_reg, 16'h3C96);
    chk("R14 extra bits no second strobe", n_ctrl, 2);
  endtask

  task automatic t_div;
    logic [255:0] rd;
    xfer(8'h07, 8, 256'h0A, 0, rd);
    chk("R5 divider write", div_reg, 8'h0A);
    chk("R5 divider count", n_div, 1);
  endtask

  task automatic t_single;
    logic [255:0] rd;
    int base;
    base = n_lbl;
    xfer(8'h05, 8, 256'h3C, 0, rd);
    chk("R6 single set", tbl, 256'h1 << 8'h3C);
    xfer(8'h05, 8, 256'hFF, 0, rd);
    xfer(8'h04, 8, 256'h3C, 0, rd);
    chk("R6 single clear", tbl, 256'h1 << 8'hFF);
    chk("R6 pulse count", n_lbl - base, 3);
  endtask

  task automatic t_table;
    logic [255:0] pat, rd;
    int base;
    for (int i = 0; i < 256; i++) pat[i] = ((i % 3) == 0) ^ ((i / 16) % 2 == 1);
    base = n_lbl;
    xfer(8'h06, 256, pat, 0, rd);
    chk("R7 table write contents", tbl, pat);
    chk("R7 table write pulses", n_lbl - base, 256);
    xfer(8'h0D, 0, 0, 256, rd);
    chk("R11 table read descending", rd, pat);
  endtask

  task automatic t_regs;
    logic [255:0] rd;
    xfer(8'h0A, 0, 0, 16, rd);
    chk("R8 status read then zeros", rd, 256'h5A00);
    xfer(8'h0B, 0, 0, 16, rd);
    chk("R8 control read", rd, {240'd0, ctrl_reg});
    xfer(8'h0C, 0, 0, 8, rd);
    chk("R8 divider read", rd, 256'h0A);
  endtask

  task automatic t_fifo;
    logic [255:0] rd;
    int base;
    base = n_pop;
    push(32'hCAFE_1234);
    xfer(8'h08, 0, 0, 40, rd);
    chk("R9 fifo word then zeros", rd, {32'hCAFE_1234, 8'h00});
    chk("R9 one pop", n_pop - base, 1);
    xfer(8'h08, 0, 0, 32, rd);
    chk("R9 empty reads zeros", rd, 0);
    chk("R9 empty no pop", n_pop - base, 1);
  endtask

  task automatic t_dump;
    logic [255:0] rd;
    int base;
    base = n_pop;
    push(32'h1357_9BDF);
    push(32'h8642_ECA0);
    xfer(8'h09, 0, 0, 96, rd);
    chk("R10 dump stream", rd, {32'h1357_9BDF, 32'h8642_ECA0, 32'h0});
    chk("R10 dump pops", n_pop - base, 2);
  endtask

  task automatic t_unimpl;
    logic [255:0] rd;
    logic [7:0] ops [0:4];
    int sum0;
    ops[0] = 8'h00; ops[1] = 8'h0E; ops[2] = 8'h0F; ops[3] = 8'h11; ops[4] = 8'hFF;
    sum0 = n_mr + n_ctrl + n_div + n_lbl + n_pop + n_clr + n_set;
    for (int k = 0; k < 5; k++) begin
      xfer(ops[k], 0, 0, 16, rd);
      chk($sformatf("R12 opcode %02h no output", ops[k]), rd, 0);
      xfer(ops[k], 16, 256'hFFFF, 0, rd);
    end
    chk("R12 no strobes", n_mr + n_ctrl + n_div + n_lbl + n_pop + n_clr + n_set, sum0);
  endtask

  task automatic t_abort;
    logic [255:0] rd;
    logic r;
    int base;
    base = n_ctrl;
    cs_n = 0; #100;
    for (int i = 7; i >= 0; i--) sbit(i == 4, r);
    for (int i = 0; i < 10; i++) sbit(1'b1, r);
    #100; cs_n = 1; #200;
    chk("R13 aborted write no strobe", n_ctrl, base);
    xfer(8'h0B, 0, 0, 16, rd);
    chk("R13 fresh opcode after abort", rd, 256'h3C96);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #55 rst_n = 1;
    #50;
    t_reset;
    t_mreset;
    t_all;
    t_ctrl;
    t_div;
    t_single;
    t_table;
    t_regs;
    t_fifo;
    t_dump;
    t_unimpl;
    t_abort;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule